// File: doc/BRIEF.md
# Periodic Memory Training Scheduler

This block decides when a memory controller should run its calibration routines. Software programs a single 32-bit control word through a simple write/read port. That word sets a prescaler counted in refresh periods and three training intervals counted in prescaler expiries. The controller supplies one tick per refresh period. The block turns those ticks into requests for three incremental trainings: write leveling, read strobe gate training and read data eye training.

Software can also ask for a one-shot full read and write leveling by writing a 1 to the top bit. That request takes precedence over any incremental work. Every request stays high until the controller acknowledges it. The training procedures, refresh generation and delay-line adjustment all live outside this block.

Top module: `train_sched`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `full_req` is 0 and `inc_req` is 0. Every incremental training is disabled because all of its fields are zero.
- R2: A write stores `cfg_wdata[30:0]` as follows: bits 30:24 hold the prescaler, bits 23:16 the read data eye interval, bits 15:8 the read gate interval and bits 7:0 the write leveling interval. From the next cycle, `cfg_rdata` returns these bits with bit 31 always 0.
- R3: With a prescaler value P, one prescaler expiry occurs on every (P+1)-th `refresh_tick`, counted from the last restart.
- R4: With a nonzero interval N, the matching request is raised on every N-th prescaler expiry and is visible on the cycle after the tick that caused it. The request bits map as follows: `inc_req[0]` is write leveling, `inc_req[1]` is read gate and `inc_req[2]` is read data eye.
- R5: An incremental request stays high until its `inc_ack` bit is seen while the request is visible. It is low from the next cycle.
- R6: An interval field of 0 never raises its request, whatever the ticks.
- R7: Expiries that occur while a request is already pending merge into it, so a single acknowledge clears it.
- R8: A write with bit 31 set raises `full_req` from the next cycle. `full_req` is held until `full_ack` and is low on the cycle after the acknowledge. The bit is not stored.
- R9: While `full_req` is high, every `inc_req` output is 0 and `inc_ack` has no effect.
- R10: An accepted `full_ack` drops all pending incremental requests and restarts the prescaler and every interval count from its programmed value.
- R11: Every register write restarts the prescaler and reloads every interval count from the newly written fields.
- R12: `inc_ack` or `full_ack` without a matching pending request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| refresh_tick | input | 1 | One-cycle pulse per refresh period |
| full_req | output | 1 | Full leveling request |
| full_ack | input | 1 | Full leveling acknowledge |
| inc_req | output | 3 | Incremental training requests |
| inc_ack | input | 3 | Incremental training acknowledges |

## Verification
A wrong prescaler or interval count shows at the ports as a request that rises one or more prescaler periods early or late. The bench detects this on the first expiry that should or should not raise a request, so within a few ticks of the fault. A lost pending bit, or a mask that fails during full leveling, changes `inc_req` on the cycle after the acknowledge or trigger. A reload that is missing after a write or after full leveling shows as a request that arrives before its reprogrammed interval has elapsed.

// File: rtl/train_sched_pkg.sv
package train_sched_pkg;
    localparam int DEF_PRE_W = 7;
    localparam int DEF_INT_W = 8;
    localparam int DEF_N_INC = 3;

    // low bit of interval field idx inside the stored word
    function automatic int fld_lsb(input int idx, input int w);
        return idx * w;
    endfunction
endpackage

// File: rtl/ts_cfg_reg.sv
module ts_cfg_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             full_ack_i,
    output logic [REG_W-2:0] cfg_o,
    output logic [REG_W-2:0] cfg_next_o,
    output logic             full_req_o,
    output logic             full_done_o,
    output logic             restart_o
);
    localparam int CW = REG_W - 1;

    typedef struct packed {
        logic [CW-1:0] cfg;
        logic          full;
    } cfg_st_t;

    cfg_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (full_ack_i && st_q.full) begin
            st_d.full = 1'b0;
        end
        if (wr_en_i) begin
            st_d.cfg = wdata_i[CW-1:0];
            if (wdata_i[REG_W-1]) begin
                st_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o       = st_q.cfg;
    assign cfg_next_o  = st_d.cfg;
    assign full_req_o  = st_q.full;
    assign full_done_o = full_ack_i & st_q.full;
    assign restart_o   = wr_en_i | (full_ack_i & st_q.full);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !full_ack_i) |=> st_q.full);
endmodule

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic             expire_o
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_q, st_d;
    logic    expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= limit_i) begin
                st_d.cnt = '0;
                expire_d = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = expire_d;

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit_i);
endmodule

// File: rtl/ts_interval.sv
module ts_interval #(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [INT_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             clear_i,
    input  logic             mask_i,
    input  logic             ack_i,
    input  logic [INT_W-1:0] period_i,
    output logic             req_o
);
    localparam logic [INT_W-1:0] ONE = INT_W'(1);

    typedef struct packed {
        logic [INT_W-1:0] cnt;
        logic             pend;
    } int_st_t;

    int_st_t st_q, st_d;
    logic    fire;
    logic    ack_take;

    assign ack_take = ack_i & st_q.pend & ~mask_i;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (step_i && (period_i != '0)) begin
            if (st_q.cnt <= ONE) begin
                fire     = 1'b1;
                st_d.cnt = period_i;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (ack_take) begin
            st_d.pend = 1'b0;
        end
        if (fire) begin
            st_d.pend = 1'b1;
        end
        if (reload_i) begin
            st_d.cnt = load_val_i;
        end
        if (clear_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.pend & ~mask_i;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !ack_take && !clear_i) |=> st_q.pend);

    // R6
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0 && !st_q.pend) |=> !st_q.pend);
endmodule

// File: rtl/train_sched.sv
module train_sched
    import train_sched_pkg::*;
#(
    parameter int PRE_W = DEF_PRE_W,
    parameter int INT_W = DEF_INT_W,
    parameter int N_INC = DEF_N_INC,
    localparam int REG_W = 1 + PRE_W + N_INC * INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             refresh_tick,
    output logic             full_req,
    input  logic             full_ack,
    output logic [N_INC-1:0] inc_req,
    input  logic [N_INC-1:0] inc_ack
);
    localparam int PRE_LSB = N_INC * INT_W;

    logic [REG_W-2:0] cfg_q;
    logic [REG_W-2:0] cfg_nx;
    logic             full_q;
    logic             full_done;
    logic             restart;
    logic             pre_exp;

    ts_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_wr_en),
        .wdata_i    (cfg_wdata),
        .full_ack_i (full_ack),
        .cfg_o      (cfg_q),
        .cfg_next_o (cfg_nx),
        .full_req_o (full_q),
        .full_done_o(full_done),
        .restart_o  (restart)
    );

    ts_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .tick_i   (refresh_tick),
        .limit_i  (cfg_q[PRE_LSB +: PRE_W]),
        .expire_o (pre_exp)
    );

    for (genvar gi = 0; gi < N_INC; gi++) begin : g_inc
        localparam int LSB = fld_lsb(gi, INT_W);
        ts_interval #(.INT_W(INT_W)) u_int (
            .clk       (clk),
            .rst_n     (rst_n),
            .reload_i  (restart),
            .load_val_i(cfg_nx[LSB +: INT_W]),
            .step_i    (pre_exp),
            .clear_i   (full_done),
            .mask_i    (full_q),
            .ack_i     (inc_ack[gi]),
            .period_i  (cfg_q[LSB +: INT_W]),
            .req_o     (inc_req[gi])
        );
    end

    assign full_req  = full_q;
    assign cfg_rdata = {1'b0, cfg_q};

    // R10
    full_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && full_ack && !cfg_wr_en) |=> (!full_req && inc_req == '0));

    // R9
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && full_ack == 1'b0 && !cfg_wr_en && !refresh_tick) |=> (inc_req == '0));
endmodule

// File: tb/train_sched_tb.sv
module train_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        refresh_tick = 1'b0;
    logic        full_req;
    logic        full_ack = 1'b0;
    logic [2:0]  inc_req;
    logic [2:0]  inc_ack = 3'b000;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    train_sched u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .refresh_tick(refresh_tick),
        .full_req    (full_req),
        .full_ack    (full_ack),
        .inc_req     (inc_req),
        .inc_ack     (inc_ack)
    );

    // sel: 0 rdata, 1 inc_req, 2 full_req
    task automatic push(input int sel, input logic [31:0] v, input string tag);
        exp_t e;
        e.sel = sel; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr_en = 1'b0; cfg_wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); refresh_tick = 1'b1;
            @(negedge clk); refresh_tick = 1'b0;
        end
    endtask

    task automatic ack_inc(input logic [2:0] m);
        @(negedge clk); inc_ack = m;
        @(negedge clk); inc_ack = 3'b000;
    endtask

    task automatic ack_full();
        @(negedge clk); full_ack = 1'b1;
        @(negedge clk); full_ack = 1'b0;
    endtask

    // monitor: compare queued expectations after each rising edge
    initial begin
        forever begin
            logic [31:0] got;
            @(posedge clk);
            #2;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                case (e.sel)
                    0:       got = cfg_rdata;
                    1:       got = {29'b0, inc_req};
                    default: got = {31'b0, full_req};
                endcase
                total++;
                if (got !== e.val) begin
                    bad++;
                    $display("FAIL %s got=%h exp=%h", e.tag, got, e.val);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(0, 32'h0, "R1 rdata after reset");
        push(1, 32'h0, "R1 inc_req after reset");
        push(2, 32'h0, "R1 full_req after reset");
        ticks(4);
        push(1, 32'h0, "R1 disabled after reset");

        // pre=1, eye=2, gate=0, write=1
        wr(32'h0102_0001);
        push(0, 32'h0102_0001, "R2 readback");
        ticks(1);
        push(1, 32'h0, "R3 no expiry after one tick");
        ticks(1);
        push(1, 32'h1, "R4 write leveling on first expiry");
        ticks(2);
        push(1, 32'h5, "R7 merge plus R4 eye on second expiry");
        ack_inc(3'b001);
        push(1, 32'h4, "R5 write ack clears only its request");
        push(1, 32'h4, "R7 single ack clears merged request");
        ack_inc(3'b100);
        push(1, 32'h0, "R5 eye ack");
        ack_inc(3'b111);
        ack_full();
        push(1, 32'h0, "R12 stray inc ack");
        push(2, 32'h0, "R12 stray full ack");
        ticks(2);
        push(1, 32'h1, "R6 gate interval zero stays off");
        ack_inc(3'b001);

        // full trigger, same fields
        wr(32'h8102_0001);
        push(2, 32'h1, "R8 full_req raised");
        push(0, 32'h0102_0001, "R8 trigger bit reads 0");
        ticks(2);
        push(1, 32'h0, "R9 incremental masked");
        push(2, 32'h1, "R8 full_req held");
        ack_inc(3'b001);
        ack_full();
        push(2, 32'h0, "R8 full_req dropped after ack");
        push(1, 32'h0, "R10 pending dropped");
        ticks(1);
        push(1, 32'h0, "R10 prescaler restarted");
        ticks(1);
        push(1, 32'h1, "R10 intervals restarted");
        ack_inc(3'b001);

        // eye count is 1 now; a write must reload it to 2
        wr(32'h0102_0000);
        ticks(2);
        push(1, 32'h0, "R11 eye reloaded by write");
        ticks(2);
        push(1, 32'h4, "R11 eye fires after full reloaded interval");
        ack_inc(3'b100);

        // prescaler 3 -> four ticks per expiry
        wr(32'h0300_0001);
        ticks(3);
        push(1, 32'h0, "R3 no expiry after three ticks");
        ticks(1);
        push(1, 32'h1, "R3 expiry on fourth tick");
        ack_inc(3'b001);
        push(1, 32'h0, "R5 final ack");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule